// File: doc/BRIEF.md
# Pipelined Carry-Save Array Multiplier

This block multiplies two unsigned 8-bit integers and returns the 16-bit product through a fixed four-stage arithmetic pipeline. The first stage forms the eight shifted partial products in parallel. The next two stages merge them with 3:2 carry-save adders that have no carry propagation inside them:

- The second stage takes eight operands down to four.
- The third stage takes four operands down to two.

The last stage resolves the remaining pair with a ripple-carry adder.

Five register banks hold the operands and their valid flag:

- one bank at the input,
- one bank between each pair of adjacent stages,
- one bank at the output.

The block accepts a new operand pair on every clock cycle and has no stall path. The valid flag travels with the data, so a result appears together with `out_valid` a fixed number of edges after its operands were taken. Carries out of bit 15 are dropped. The exact product of two 8-bit values always fits in 16 bits.

Top module: `csa_mult_pipe`

## Requirements
- R1: For every operand pair taken with `in_valid` high, `out_p` equals the unsigned product `in_a * in_b` as a 16-bit value.
- R2: A pair sampled at a rising edge (edge 1) shows up on `out_p` with `out_valid` high right after the fifth rising edge counted from, and including, that sampling edge.
- R3: Pairs driven on consecutive cycles produce results on consecutive cycles, in the same order, with no gap.
- R4: A cycle in which `in_valid` is low yields `out_valid` low in the matching output slot, five edges later.
- R5: A rising edge with `rst` high drives `out_valid` to 0 and `out_p` to 0 after that edge. It also discards every pair in flight: nothing from those pairs reaches the output after reset is released.
- R6: Each compression stage preserves the arithmetic total modulo 2^16. The sum of the four operands after stage 2 equals the sum of the eight partial products one cycle earlier. The sum of the two operands after stage 3 equals the sum of the four operands one cycle earlier.
- R7: The extreme operands are exact. Any operand of 0 gives a product of 0. The pair 255 by 255 gives 65025, and 255 by 1 gives 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all banks update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_a` and `in_b` as a pair to multiply |
| in_a | input | 8 | Multiplicand, unsigned |
| in_b | input | 8 | Multiplier, unsigned |
| out_valid | output | 1 | High when `out_p` carries a result |
| out_p | output | 16 | Product, unsigned |

## Verification
The assertions assume that the inputs sampled in the five edges since reset are the ones whose results are on the output now. For this reason they stay silent until five non-reset edges have passed, and they reason only about post-reset samples. They also assume `in_valid` is low while `rst` is high. The stimulus keeps to both assumptions: it holds `in_valid` low whenever it raises `rst`, and it waits through the first five edges after reset before expecting any result. The stimulus covers the full operand space back to back, directed extremes separated by idle cycles, and a reset raised while pairs are still in the pipeline.

// File: rtl/mp_pkg.sv
package mp_pkg;
  parameter int unsigned OPW = 8;          // operand width
  localparam int unsigned PW  = 2 * OPW;   // product width
  localparam int unsigned NPP = OPW;       // partial product count

  typedef logic [PW-1:0] word_t;

  // 3:2 compressor sum vector: bitwise parity of the three inputs
  function automatic word_t csa_sum(input word_t x, input word_t y, input word_t z);
    return x ^ y ^ z;
  endfunction

  // 3:2 compressor carry vector: bitwise majority, moved one place up
  function automatic word_t csa_cry(input word_t x, input word_t y, input word_t z);
    return ((x & y) | (y & z) | (x & z)) << 1;
  endfunction
endpackage

// File: rtl/mp_ppgen.sv
module mp_ppgen
  import mp_pkg::*;
(
  input  logic [OPW-1:0]          mcand,
  input  logic [OPW-1:0]          mplier,
  output logic [NPP-1:0][PW-1:0]  pp
);
  for (genvar i = 0; i < NPP; i++) begin : g_row
    assign pp[i] = mplier[i] ? (word_t'(mcand) << i) : '0;
  end
endmodule

// File: rtl/mp_csa.sv
module mp_csa
  import mp_pkg::*;
(
  input  word_t x,
  input  word_t y,
  input  word_t z,
  output word_t s,
  output word_t c
);
  assign s = csa_sum(x, y, z);
  assign c = csa_cry(x, y, z);
endmodule

// File: rtl/mp_ripple.sv
module mp_ripple #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  output logic [N-1:0] sum
);
  logic [N-1:0] cin;   // carry into each bit position
  assign cin[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign sum[i] = x[i] ^ y[i] ^ cin[i];
    if (i < N - 1) begin : g_cy
      assign cin[i+1] = (x[i] & y[i]) | (cin[i] & (x[i] ^ y[i]));
    end
  end
endmodule

// File: rtl/csa_mult_pipe.sv
module csa_mult_pipe
  import mp_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [OPW-1:0]  in_a,
  input  logic [OPW-1:0]  in_b,
  output logic            out_valid,
  output logic [PW-1:0]   out_p
);
  // bank 0: input
  logic [OPW-1:0] a_q, b_q;
  logic           v0_q;
  // bank 1: partial products
  logic [NPP-1:0][PW-1:0] pp_c, pp_q;
  logic                   v1_q;
  // bank 2: four operands
  logic [3:0][PW-1:0] st2_c, st2_q;
  logic               v2_q;
  // bank 3: two operands
  logic [1:0][PW-1:0] st3_c, st3_q;
  logic               v3_q;
  // stage 4 result
  word_t fin_c;

  // running totals of each bank, brought out for the checker
  word_t tot1, tot2, tot3;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0; b_q <= '0; v0_q <= 1'b0;
      pp_q <= '0; v1_q <= 1'b0;
      st2_q <= '0; v2_q <= 1'b0;
      st3_q <= '0; v3_q <= 1'b0;
      out_p <= '0; out_valid <= 1'b0;
    end else begin
      a_q <= in_a;   b_q <= in_b;  v0_q <= in_valid;
      pp_q <= pp_c;  v1_q <= v0_q;
      st2_q <= st2_c; v2_q <= v1_q;
      st3_q <= st3_c; v3_q <= v2_q;
      out_p <= fin_c; out_valid <= v3_q;
    end
  end

  // stage 1: partial products
  mp_ppgen u_pp (.mcand(a_q), .mplier(b_q), .pp(pp_c));

  // stage 2: eight to four, two levels
  word_t s_a, c_a, s_b, c_b;
  mp_csa u_l1a (.x(pp_q[0]), .y(pp_q[1]), .z(pp_q[2]), .s(s_a), .c(c_a));
  mp_csa u_l1b (.x(pp_q[3]), .y(pp_q[4]), .z(pp_q[5]), .s(s_b), .c(c_b));
  mp_csa u_l2a (.x(s_a), .y(c_a), .z(s_b), .s(st2_c[0]), .c(st2_c[1]));
  mp_csa u_l2b (.x(c_b), .y(pp_q[6]), .z(pp_q[7]), .s(st2_c[2]), .c(st2_c[3]));

  // stage 3: four to two, two levels
  word_t s_e, c_e;
  mp_csa u_l3a (.x(st2_q[0]), .y(st2_q[1]), .z(st2_q[2]), .s(s_e), .c(c_e));
  mp_csa u_l3b (.x(s_e), .y(c_e), .z(st2_q[3]), .s(st3_c[0]), .c(st3_c[1]));

  // stage 4: ripple-carry resolve
  mp_ripple #(.N(PW)) u_rca (.x(st3_q[0]), .y(st3_q[1]), .sum(fin_c));

  always_comb begin
    tot1 = '0;
    for (int i = 0; i < NPP; i++) tot1 = tot1 + pp_q[i];
    tot2 = st2_q[0] + st2_q[1] + st2_q[2] + st2_q[3];
    tot3 = st3_q[0] + st3_q[1];
  end
endmodule

// File: rtl/csa_mult_pipe_chk.sv
module csa_mult_pipe_chk
  import mp_pkg::*;
(
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [OPW-1:0] in_a,
  input logic [OPW-1:0] in_b,
  input logic           out_valid,
  input logic [PW-1:0]  out_p,
  input word_t          tot1,
  input word_t          tot2,
  input word_t          tot3
);
  logic [2:0] since_rst;   // non-reset edges seen, saturating at 5
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 3'd5) since_rst <= since_rst + 3'd1;
  end

  a_r1_product: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd5 && out_valid) |->
      out_p == (word_t'($past(in_a, 5)) * word_t'($past(in_b, 5))));

  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd5) |-> (out_valid == $past(in_valid, 5)));

  a_r4_bubble: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd5 && !$past(in_valid, 5)) |-> !out_valid);

  a_r5_reset: assert property (@(posedge clk)
    rst |=> (!out_valid && out_p == '0));

  a_r6_conserve: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 3'd0) |-> (tot2 == $past(tot1) && tot3 == $past(tot2)));
endmodule

bind csa_mult_pipe csa_mult_pipe_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
  .out_valid(out_valid), .out_p(out_p),
  .tot1(tot1), .tot2(tot2), .tot3(tot3)
);

// File: tb/sim_csa_mult_pipe.sv
module sim_csa_mult_pipe;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iv  = 1'b0;
  logic [7:0]  a   = '0;
  logic [7:0]  b   = '0;
  logic        ov;
  logic [15:0] p;

  int compared = 0;
  int mismatched = 0;
  int tick_n = 0;
  string phase = "init";

  // reference model: pending pairs and the tick they are due
  int qa[$];
  int qb[$];
  int qd[$];

  always #4 clk = ~clk;   // 125 MHz

  csa_mult_pipe u0 (.clk(clk), .rst(rst), .in_valid(iv), .in_a(a), .in_b(b),
                    .out_valid(ov), .out_p(p));

  task automatic tick(input logic r, input logic v, input int x, input int y);
    @(negedge clk);
    tick_n++;
    compared++;
    if (rst) begin
      if (ov !== 1'b0 || p !== 16'd0) begin
        mismatched++;
        $display("FAIL R5 (%s) tick %0d: valid=%b p=%0d expected valid=0 p=0",
                 phase, tick_n, ov, p);
      end
    end else if (qd.size() > 0 && qd[0] == tick_n) begin
      // R1 R2 R3 R6 R7: product due exactly now
      if (ov !== 1'b1 || p !== 16'(qa[0] * qb[0])) begin
        mismatched++;
        $display("FAIL R1/R2 (%s) tick %0d: %0d*%0d valid=%b p=%0d expected valid=1 p=%0d",
                 phase, tick_n, qa[0], qb[0], ov, p, qa[0] * qb[0]);
      end
      void'(qa.pop_front()); void'(qb.pop_front()); void'(qd.pop_front());
    end else begin
      if (ov !== 1'b0) begin
        mismatched++;
        $display("FAIL R4 (%s) tick %0d: valid=%b expected 0", phase, tick_n, ov);
      end
    end
    rst = r;
    iv  = v & ~r;
    a   = 8'(x);
    b   = 8'(y);
    if (r) begin
      while (qd.size() > 0 && qd[$] > tick_n) begin
        void'(qa.pop_back()); void'(qb.pop_back()); void'(qd.pop_back());
      end
    end else if (v) begin
      qa.push_back(x); qb.push_back(y); qd.push_back(tick_n + 5);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick(1'b0, 1'b0, 0, 0);
  endtask

  initial begin
    phase = "R5 reset state";
    for (int k = 0; k < 3; k++) tick(1'b1, 1'b0, 0, 0);
    idle(6);

    phase = "R7 extremes";
    tick(1'b0, 1'b1, 255, 255); idle(1);
    tick(1'b0, 1'b1, 255, 1);   idle(2);
    tick(1'b0, 1'b1, 0, 255);
    tick(1'b0, 1'b1, 255, 0);
    tick(1'b0, 1'b1, 128, 128); idle(1);
    tick(1'b0, 1'b1, 1, 255);
    idle(6);

    phase = "R3 exhaustive back-to-back";
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        tick(1'b0, 1'b1, i, j);
    idle(6);

    phase = "R4 alternating bubbles";
    for (int k = 0; k < 20; k++) begin
      tick(1'b0, 1'b1, (k * 37) & 255, (k * 91 + 5) & 255);
      idle(k % 3);
    end
    idle(6);

    phase = "R5 mid-stream reset";
    for (int k = 0; k < 4; k++) tick(1'b0, 1'b1, 200 + k, 17 + k);
    tick(1'b1, 1'b0, 0, 0);
    tick(1'b1, 1'b0, 0, 0);
    idle(8);

    phase = "R1 after reset";
    for (int k = 0; k < 8; k++) tick(1'b0, 1'b1, 255 - k, 3 * k);
    idle(7);

    if (qd.size() != 0) begin
      mismatched++;
      $display("FAIL R2: %0d results never arrived, expected 0", qd.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule